// File: doc/BRIEF.md
# Debug Register Access Trap Arbiter

This block rules on a system-register read or write aimed at the watchpoint control registers of a processor's self-hosted debug logic. With each request it receives the current exception level, a read/write flag, the five fields of the register encoding, and a set of configuration bits taken from the hypervisor, monitor, OS-lock and external-debug state. It then returns exactly one outcome: undefined, trap to level 2, trap to level 3, debug halt, or perform the access. It does not hold the register contents. Storage lives elsewhere and acts only on a "perform" result.

The checks form a fixed priority chain, and the chain is shorter at higher exception levels. At level 1 the order is: the per-register fine-grained trap, then the hypervisor debug traps, then the monitor debug trap, then the halt check. Level 2 starts at the monitor check. Level 3 applies only the halt check. If an encoding does not select this register family, the block reports that the encoding is not its own, so that a neighbouring decoder can claim it.

The result is registered. It appears one cycle after the request strobe, together with a one-cycle done pulse, the trap syndrome class and the selected watchpoint index.

Top module: `dbg_access_arbiter`

## Requirements
- R1: The register is selected when op0=2'b10, op1=3'b000, CRn=4'b0000 and op2=3'b111. For any other encoding the result has not_mine_o=1, outcome_o=0, ec_o=0 and index_o=0.
- R2: outcome_o is one-hot with these bit positions: bit0 perform, bit1 undefined, bit2 trap to level 2, bit3 trap to level 3, bit4 halt. It is valid together with a one-cycle done_o, which follows the clock edge where req_i=1 was sampled. Out of reset and on cycles with no request, done_o is 0. The reset value of outcome_o is 0.
- R3: A selected access from level 0 (el_i=0) is undefined.
- R4: index_o carries CRm. At levels 1 to 3, a CRm value of NUM_WP or more is undefined, and this check takes priority over every trap.
- R5: At level 1, the access traps to level 2 when all of the following hold: level 2 is enabled and in 64-bit state; either level 3 is absent or fgt_ena_i=1; and the access's fine-grained bit is 1.
- R6: At level 1, if R5 does not fire, the access traps to level 2 when level 2 is enabled, is in 64-bit state, and hyp_gen_trap_i or hyp_dbg_trap_i is set.
- R7: At levels 1 and 2, after the level-2 checks, the access traps to level 3 when level 3 is present, is in 64-bit state, and has mon_dbg_trap_i=1.
- R8: At levels 1, 2 and 3, after the trap checks, the access halts when level 1 is in 64-bit state, the OS lock is clear, halting is allowed and ext_dbg_trap_i=1. A level-3 access never traps.
- R9: When no rule above fires, the access is performed. A trap result reports ec_o=6'h18. Every other result reports ec_o=0.
- R10: A read consults only fgt_rd_i and a write consults only fgt_wr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| el_i | input | 2 | Current exception level |
| is_write_i | input | 1 | 1 = write, 0 = read |
| op0_i | input | 2 | Encoding op0 |
| op1_i | input | 3 | Encoding op1 |
| crn_i | input | 4 | Encoding CRn |
| crm_i | input | 4 | Encoding CRm (watchpoint index) |
| op2_i | input | 3 | Encoding op2 |
| el2_ena_i | input | 1 | Level 2 enabled |
| el2_aa64_i | input | 1 | Level 2 in 64-bit state |
| el3_present_i | input | 1 | Level 3 implemented |
| el3_aa64_i | input | 1 | Level 3 in 64-bit state |
| fgt_ena_i | input | 1 | Fine-grained trap enable from level 3 |
| fgt_rd_i | input | 1 | Fine-grained read-trap bit for this register |
| fgt_wr_i | input | 1 | Fine-grained write-trap bit for this register |
| hyp_gen_trap_i | input | 1 | Hypervisor general debug trap |
| hyp_dbg_trap_i | input | 1 | Hypervisor debug-access trap |
| mon_dbg_trap_i | input | 1 | Monitor debug-access trap |
| el1_aa64_i | input | 1 | Level 1 in 64-bit state |
| os_locked_i | input | 1 | OS lock set |
| halt_ok_i | input | 1 | Halting allowed |
| ext_dbg_trap_i | input | 1 | External debugger access trap |
| done_o | output | 1 | Result valid pulse |
| outcome_o | output | 5 | One-hot outcome |
| not_mine_o | output | 1 | Encoding not claimed |
| ec_o | output | 6 | Syndrome exception class |
| index_o | output | 4 | Selected watchpoint index |

## Verification
Several trap rules can be armed in the same request. The clearest case is a level-1 access with the fine-grained bit, a hypervisor bit, the monitor bit and the external-debugger bit all set at once, possibly combined with an out-of-range index. The bench sets these bits independently at random and adds directed requests that arm every rule together. It then lowers the rules one at a time to step down the chain. Each result is judged against a bench model that walks the priority order given in the requirements, so the outcome must name the highest-ranked rule that fires and never any rule below it.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  localparam int unsigned OC_W   = 5;
  localparam int unsigned EC_W   = 6;
  localparam int unsigned IDX_W  = 4;

  localparam int unsigned OC_ACCESS = 0;
  localparam int unsigned OC_UNDEF  = 1;
  localparam int unsigned OC_TRAP2  = 2;
  localparam int unsigned OC_TRAP3  = 3;
  localparam int unsigned OC_HALT   = 4;

  localparam logic [EC_W-1:0] EC_DBG_TRAP = 6'h18;

  localparam logic [1:0] SEL_OP0 = 2'b10;
  localparam logic [2:0] SEL_OP1 = 3'b000;
  localparam logic [3:0] SEL_CRN = 4'b0000;
  localparam logic [2:0] SEL_OP2 = 3'b111;

  typedef struct packed {
    logic el2_ena;
    logic el2_aa64;
    logic el3_present;
    logic el3_aa64;
    logic fgt_ena;
    logic fgt_rd;
    logic fgt_wr;
    logic hyp_gen_trap;
    logic hyp_dbg_trap;
    logic mon_dbg_trap;
    logic el1_aa64;
    logic os_locked;
    logic halt_ok;
    logic ext_dbg_trap;
  } trap_cfg_t;
endpackage

// File: rtl/dbg_enc_decode.sv
module dbg_enc_decode
  import dbg_arb_pkg::*;
#(
  parameter int unsigned NUM_WP = 4
) (
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [IDX_W-1:0] crm_i,
  input  logic [2:0]       op2_i,
  output logic             hit_o,
  output logic             idx_ok_o
);
  localparam int unsigned IDX_SPAN = 1 << IDX_W;

  assign hit_o = (op0_i == SEL_OP0) && (op1_i == SEL_OP1) &&
                 (crn_i == SEL_CRN) && (op2_i == SEL_OP2);

  generate
    if (NUM_WP >= IDX_SPAN) begin : g_full
      assign idx_ok_o = 1'b1;
    end else begin : g_part
      localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_WP);
      assign idx_ok_o = (crm_i < LIMIT);
    end
  endgenerate
endmodule

// File: rtl/dbg_trap_chain.sv
module dbg_trap_chain
  import dbg_arb_pkg::*;
(
  input  logic [1:0]      el_i,
  input  logic            is_write_i,
  input  logic            idx_ok_i,
  input  trap_cfg_t       cfg_i,
  output logic [OC_W-1:0] oc_o
);
  logic el2_live, fgt_bit;
  logic c_fgt, c_hyp, c_mon, c_halt;

  assign el2_live = cfg_i.el2_ena & cfg_i.el2_aa64;
  assign fgt_bit  = is_write_i ? cfg_i.fgt_wr : cfg_i.fgt_rd;
  assign c_fgt    = el2_live & (~cfg_i.el3_present | cfg_i.fgt_ena) & fgt_bit;
  assign c_hyp    = el2_live & (cfg_i.hyp_gen_trap | cfg_i.hyp_dbg_trap);
  assign c_mon    = cfg_i.el3_present & cfg_i.el3_aa64 & cfg_i.mon_dbg_trap;
  assign c_halt   = cfg_i.el1_aa64 & ~cfg_i.os_locked & cfg_i.halt_ok & cfg_i.ext_dbg_trap;

  always_comb begin
    oc_o = '0;
    unique case (el_i)
      2'd0: oc_o[OC_UNDEF] = 1'b1;
      2'd1: begin
        if (!idx_ok_i)          oc_o[OC_UNDEF]  = 1'b1;
        else if (c_fgt | c_hyp) oc_o[OC_TRAP2]  = 1'b1;
        else if (c_mon)         oc_o[OC_TRAP3]  = 1'b1;
        else if (c_halt)        oc_o[OC_HALT]   = 1'b1;
        else                    oc_o[OC_ACCESS] = 1'b1;
      end
      2'd2: begin
        if (!idx_ok_i)          oc_o[OC_UNDEF]  = 1'b1;
        else if (c_mon)         oc_o[OC_TRAP3]  = 1'b1;
        else if (c_halt)        oc_o[OC_HALT]   = 1'b1;
        else                    oc_o[OC_ACCESS] = 1'b1;
      end
      default: begin
        if (!idx_ok_i)          oc_o[OC_UNDEF]  = 1'b1;
        else if (c_halt)        oc_o[OC_HALT]   = 1'b1;
        else                    oc_o[OC_ACCESS] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dbg_result_reg.sv
module dbg_result_reg
  import dbg_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             hit_i,
  input  logic [OC_W-1:0]  oc_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             done_o,
  output logic [OC_W-1:0]  outcome_o,
  output logic             not_mine_o,
  output logic [EC_W-1:0]  ec_o,
  output logic [IDX_W-1:0] index_o
);
  logic [OC_W-1:0] oc_q;
  logic is_trap;

  assign oc_q    = hit_i ? oc_i : '0;
  assign is_trap = oc_q[OC_TRAP2] | oc_q[OC_TRAP3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      outcome_o  <= '0;
      not_mine_o <= 1'b0;
      ec_o       <= '0;
      index_o    <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        outcome_o  <= oc_q;
        not_mine_o <= ~hit_i;
        ec_o       <= is_trap ? EC_DBG_TRAP : '0;
        index_o    <= hit_i ? idx_i : '0;
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (($countones(outcome_o) == 1) != not_mine_o)); // R2
  AST_NOT_MINE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && not_mine_o) |-> (outcome_o == '0 && ec_o == '0 && index_o == '0)); // R1
  AST_TRAP_EC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (outcome_o[OC_TRAP2] || outcome_o[OC_TRAP3])) |-> ec_o == EC_DBG_TRAP); // R9
endmodule

// File: rtl/dbg_access_arbiter.sv
module dbg_access_arbiter
  import dbg_arb_pkg::*;
#(
  parameter int unsigned NUM_WP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       el_i,
  input  logic             is_write_i,
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [3:0]       crm_i,
  input  logic [2:0]       op2_i,
  input  logic             el2_ena_i,
  input  logic             el2_aa64_i,
  input  logic             el3_present_i,
  input  logic             el3_aa64_i,
  input  logic             fgt_ena_i,
  input  logic             fgt_rd_i,
  input  logic             fgt_wr_i,
  input  logic             hyp_gen_trap_i,
  input  logic             hyp_dbg_trap_i,
  input  logic             mon_dbg_trap_i,
  input  logic             el1_aa64_i,
  input  logic             os_locked_i,
  input  logic             halt_ok_i,
  input  logic             ext_dbg_trap_i,
  output logic             done_o,
  output logic [4:0]       outcome_o,
  output logic             not_mine_o,
  output logic [5:0]       ec_o,
  output logic [3:0]       index_o
);
  trap_cfg_t       cfg;
  logic            hit, idx_ok;
  logic [OC_W-1:0] oc;

  assign cfg = '{el2_ena: el2_ena_i, el2_aa64: el2_aa64_i, el3_present: el3_present_i,
                 el3_aa64: el3_aa64_i, fgt_ena: fgt_ena_i, fgt_rd: fgt_rd_i,
                 fgt_wr: fgt_wr_i, hyp_gen_trap: hyp_gen_trap_i,
                 hyp_dbg_trap: hyp_dbg_trap_i, mon_dbg_trap: mon_dbg_trap_i,
                 el1_aa64: el1_aa64_i, os_locked: os_locked_i,
                 halt_ok: halt_ok_i, ext_dbg_trap: ext_dbg_trap_i};

  dbg_enc_decode #(.NUM_WP(NUM_WP)) i_decode (
    .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i), .crm_i(crm_i), .op2_i(op2_i),
    .hit_o(hit), .idx_ok_o(idx_ok)
  );

  dbg_trap_chain i_chain (
    .el_i(el_i), .is_write_i(is_write_i), .idx_ok_i(idx_ok), .cfg_i(cfg), .oc_o(oc)
  );

  dbg_result_reg i_result (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .hit_i(hit), .oc_i(oc), .idx_i(crm_i),
    .done_o(done_o), .outcome_o(outcome_o), .not_mine_o(not_mine_o),
    .ec_o(ec_o), .index_o(index_o)
  );

  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o); // R2
  AST_EL0_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit && el_i == 2'd0) |=> outcome_o[OC_UNDEF]); // R3
  AST_EL3_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && el_i == 2'd3) |=> (!outcome_o[OC_TRAP2] && !outcome_o[OC_TRAP3])); // R8
  AST_BAD_IDX_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit && !idx_ok) |=> outcome_o[OC_UNDEF]); // R4
endmodule

// File: tb/test_dbg_access_arbiter.sv
module test_dbg_access_arbiter;
  localparam int unsigned NWP = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [1:0] el = '0;
  logic wr = 1'b0;
  logic [1:0] op0 = '0;
  logic [2:0] op1 = '0;
  logic [3:0] crn = '0;
  logic [3:0] crm = '0;
  logic [2:0] op2 = '0;
  logic e2en = 0, e2a64 = 0, e3p = 0, e3a64 = 0, fen = 0, frd = 0, fwr = 0;
  logic hgen = 0, hdbg = 0, mdbg = 0, e1a64 = 0, osl = 0, hok = 0, xdbg = 0;

  logic       done;
  logic [4:0] oc;
  logic       nm;
  logic [5:0] ec;
  logic [3:0] idx;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  dbg_access_arbiter #(.NUM_WP(NWP)) i_dbg_access_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .el_i(el), .is_write_i(wr),
    .op0_i(op0), .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2),
    .el2_ena_i(e2en), .el2_aa64_i(e2a64), .el3_present_i(e3p), .el3_aa64_i(e3a64),
    .fgt_ena_i(fen), .fgt_rd_i(frd), .fgt_wr_i(fwr), .hyp_gen_trap_i(hgen),
    .hyp_dbg_trap_i(hdbg), .mon_dbg_trap_i(mdbg), .el1_aa64_i(e1a64),
    .os_locked_i(osl), .halt_ok_i(hok), .ext_dbg_trap_i(xdbg),
    .done_o(done), .outcome_o(oc), .not_mine_o(nm), .ec_o(ec), .index_o(idx)
  );

  // model: {not_mine, outcome}, and tag of the deciding rule
  string rule;
  function automatic logic [5:0] model();
    logic sel, l2, f, h, m, hl;
    sel = (op0 == 2'b10) && (op1 == 3'b000) && (crn == 4'b0000) && (op2 == 3'b111);
    l2 = e2en && e2a64;
    f  = l2 && (!e3p || fen) && (wr ? fwr : frd);
    h  = l2 && (hgen || hdbg);
    m  = e3p && e3a64 && mdbg;
    hl = e1a64 && !osl && hok && xdbg;
    if (!sel)                    begin rule = "R1"; return 6'b100000; end
    if (el == 0)                 begin rule = "R3"; return 6'b000010; end
    if (crm >= NWP)              begin rule = "R4"; return 6'b000010; end
    if (el == 1 && f)            begin rule = "R5"; return 6'b000100; end
    if (el == 1 && h)            begin rule = "R6"; return 6'b000100; end
    if (el != 3 && m)            begin rule = "R7"; return 6'b001000; end
    if (hl)                      begin rule = "R8"; return 6'b010000; end
    rule = "R9"; return 6'b000001;
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // called at a negedge with inputs set
  task automatic apply();
    logic [5:0] e;
    logic [5:0] eec;
    logic [3:0] eidx;
    e = model();
    eec  = (e[2] || e[3]) ? 6'h18 : 6'h00;
    eidx = e[5] ? 4'd0 : crm;
    req = 1'b1;
    @(negedge clk_i);
    req = 1'b0;
    chk(done == 1'b1, "R2 done", int'(done), 1);
    chk({nm, oc} == e, rule, int'({nm, oc}), int'(e));
    chk(ec == eec, "R9 ec", int'(ec), int'(eec));
    chk(idx == eidx, "R4 index", int'(idx), int'(eidx));
    @(negedge clk_i);
    chk(done == 1'b0, "R2 pulse", int'(done), 0);
  endtask

  task automatic sel_enc(input logic [3:0] c);
    op0 = 2'b10; op1 = 3'b000; crn = 4'b0000; op2 = 3'b111; crm = c;
  endtask

  task automatic cfg_clear();
    {e2en, e2a64, e3p, e3a64, fen, frd, fwr, hgen, hdbg, mdbg, e1a64, osl, hok, xdbg} = '0;
  endtask

  task automatic cfg_all();
    {e2en, e2a64, e3p, e3a64, fen, frd, fwr, hgen, hdbg, mdbg, e1a64, hok, xdbg} = '1;
    osl = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(done == 1'b0 && oc == 5'b0, "R2 reset", int'({done, oc}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done == 1'b0, "R2 idle", int'(done), 0);

    // R1: foreign encodings
    cfg_clear(); el = 1;
    sel_enc(0); op2 = 3'b110; apply();
    sel_enc(0); op0 = 2'b11;  apply();
    sel_enc(0); crn = 4'b0001; apply();
    // R3: level 0
    sel_enc(1); el = 0; apply();
    // R4: index out of range beats every trap
    cfg_all(); sel_enc(4'd9); el = 1; apply();
    sel_enc(4'd3); el = 1; apply();
    // priority walk at level 1: R5 -> R6 -> R7 -> R8 -> R9
    cfg_all(); sel_enc(2); el = 1; wr = 0; apply();          // R5
    frd = 0; apply();                                        // R10 read ignores fwr=1 -> R6
    fwr = 0; frd = 1; wr = 1; apply();                       // R10 write ignores frd -> R6
    fen = 0; fwr = 1; apply();                               // R5 blocked by fen -> R6
    hgen = 0; hdbg = 0; apply();                             // R7
    mdbg = 0; apply();                                       // R8
    xdbg = 0; apply();                                       // R9
    cfg_all(); e3p = 0; fen = 0; sel_enc(0); el = 1; wr = 1; apply(); // R5 no level 3
    // level 2 skips level-2 traps
    cfg_all(); sel_enc(1); el = 2; apply();                  // R7
    mdbg = 0; apply();                                       // R8
    osl = 1; apply();                                        // R9
    // level 3: only halt
    cfg_all(); sel_enc(3); el = 3; apply();                  // R8
    e1a64 = 0; apply();                                      // R9

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      sel_enc(4'($urandom_range(0, 15)));
      if ($urandom_range(0, 7) == 0) begin
        op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom); op2 = 3'($urandom);
      end
      el = 2'($urandom); wr = 1'($urandom);
      {e2en, e2a64, e3p, e3a64, fen, frd, fwr} = 7'($urandom);
      {hgen, hdbg, mdbg, e1a64, osl, hok, xdbg} = 7'($urandom);
      if ($urandom_range(0, 1) == 0) {hgen, hdbg, frd, fwr} = '0;
      apply();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule